// File: doc/BRIEF.md
# Slow ADC Bus Interface Sequencer

This block lets a fast CPU bus drive a slow parallel analog-to-digital converter. The converter needs a start strobe and a read strobe that each stay low far longer than one bus cycle. It signals the end of a conversion on an active-low done line. A single CPU write to the device select starts a conversion. The block widens that write into a long start strobe. It then waits for the done line, makes a long read strobe, and latches the converter's data bus into a holding register on the clock edge that ends the read strobe.

Pulse widths come from counting shift ticks, not from analog timers. The tick is a clock enable taken from the system clock once every `TICK_DIV` cycles. Both strobes are built from shift chains of `STAGES` flops. The start chain is cleared by the write and refilled with ones. The read chain is a delay line on the done signal. When the converter sees its read strobe it releases the done line, and that release travels through the same delay line, so the read strobe ends by itself.

From the CPU side the whole sequence is asynchronous. Software starts a conversion and waits at least the converter's worst-case conversion time. As an alternative it can poll the busy output. It then reads the holding register, which is driven onto the CPU data bus only while the select and the read strobe are both active.

Top module: `adc_slow_seq`

## Requirements
- R1: After reset, `adc_wr_n` and `adc_rd_n` are high, `busy` is 0, the holding register is 0, and `cpu_doe` is 0 with `cpu_dout` at 0.
- R2: A write is a clock edge where `cs`=1 and `wr_n`=0. After each write edge, `adc_wr_n` is low in the following cycle.
- R3: After the last write edge, `adc_wr_n` goes high again on the `STAGES`-th shift tick. Its low time is between (STAGES-1)*TICK_DIV+1 and STAGES*TICK_DIV cycles for a one-cycle write. A write held low for more cycles extends the strobe.
- R4: `adc_rd_n` equals the value of `adc_intr_n` sampled `STAGES` shift ticks earlier and changes only on a tick. If the converter releases `adc_intr_n` in the cycle after `adc_rd_n` falls, the read strobe lasts exactly STAGES*TICK_DIV cycles.
- R5: A shift tick occurs on every `TICK_DIV`-th clock edge after reset. The first tick is on edge number `TICK_DIV`.
- R6: On the edge where `adc_rd_n` goes from low to high, the holding register takes the value of `adc_data` present at that edge.
- R7: `cpu_doe` is 1 exactly when `cs`=1 and `rd_n`=0, and at that time `cpu_dout` shows the holding register. Otherwise `cpu_dout` is 0.
- R8: `busy` becomes 1 after a write edge and returns to 0 after the capture edge of R6. A write on the capture edge keeps it at 1.
- R9: `wr_n` low while `cs`=0 starts nothing: `adc_wr_n` stays high and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Device select from the address decoder |
| wr_n | input | 1 | CPU write strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| cpu_dout | output | DATA_W | Holding register toward the CPU data bus, 0 when not selected |
| cpu_doe | output | 1 | Drive enable for the CPU data bus |
| busy | output | 1 | Conversion in flight, from write until capture |
| adc_wr_n | output | 1 | Converter start strobe, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| adc_intr_n | input | 1 | Converter conversion-done, active low |
| adc_data | input | DATA_W | Converter parallel data bus |

## Verification
The bench targets the start strobe's length against the tick phase, since a counter that is off by one gives a strobe one tick short, and that can break the converter's minimum width. It checks that holding the write extends the strobe. It also checks that a write with the select low is ignored, because a design that skips the select would start stray conversions. The read path is driven both by a converter model that releases the done line and by arbitrary done patterns. A wrong delay depth or a capture on the falling rather than the rising read edge latches stale data and ends busy in the wrong cycle. CPU reads with and without the select show whether the bus drive leaks outside a selected read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    // The read strobe ends when the tail stage is low and a high value
    // is about to shift into it on this tick.
    function automatic logic strobe_ending(input logic tick,
                                           input logic tail,
                                           input logic feed);
        return tick & ~tail & feed;
    endfunction

endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
    parameter int TICK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(TICK_DIV);
            localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                if (cnt_q == LAST) cnt_d = '0;
                else               cnt_d = cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/adc_shift_chain.sv
module adc_shift_chain #(
    parameter int   STAGES   = 4,
    parameter logic REST_VAL = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              clear,
    input  logic              sin,
    output logic [STAGES-1:0] stages
);
    logic [STAGES-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clear)         sr_d = '0;
        else if (shift_en) sr_d = {sr_q[STAGES-2:0], sin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= {STAGES{REST_VAL}};
        else        sr_q <= sr_d;
    end

    assign stages = sr_q;
endmodule

// File: rtl/adc_slow_seq.sv
module adc_slow_seq
    import adc_seq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int STAGES   = 4,
    parameter int TICK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              wr_n,
    input  logic              rd_n,
    output logic [DATA_W-1:0] cpu_dout,
    output logic              cpu_doe,
    output logic              busy,
    output logic              adc_wr_n,
    output logic              adc_rd_n,
    input  logic              adc_intr_n,
    input  logic [DATA_W-1:0] adc_data
);
    localparam int TAIL = STAGES - 1;
    localparam int FEED = STAGES - 2;

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        seq_state_e        st;
    } seq_regs_t;

    logic              tick;
    logic              write_evt;
    logic              capture;
    logic [STAGES-1:0] start_stages;
    logic [STAGES-1:0] read_stages;
    logic [DATA_W-1:0] hold_q;
    seq_regs_t         r_d, r_q;

    // CPU strobe is active low; the chain clear is active high.
    assign write_evt = cs & ~wr_n;

    adc_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // Start timer: ones refill a cleared chain, one per tick.
    adc_shift_chain #(.STAGES(STAGES), .REST_VAL(1'b1)) u_start (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (tick),
        .clear    (write_evt),
        .sin      (1'b1),
        .stages   (start_stages)
    );

    // Read path: pure delay line on the done signal.
    adc_shift_chain #(.STAGES(STAGES), .REST_VAL(1'b1)) u_read (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (tick),
        .clear    (1'b0),
        .sin      (adc_intr_n),
        .stages   (read_stages)
    );

    assign capture = strobe_ending(tick, read_stages[TAIL], read_stages[FEED]);

    always_comb begin
        r_d = r_q;
        if (capture)   r_d.hold = adc_data;
        if (write_evt) r_d.st   = SEQ_WAIT;
        else if (capture) r_d.st = SEQ_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.hold <= '0;
            r_q.st   <= SEQ_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign hold_q   = r_q.hold;
    assign busy     = (r_q.st == SEQ_WAIT);
    assign adc_wr_n = start_stages[TAIL];
    assign adc_rd_n = read_stages[TAIL];
    assign cpu_doe  = cs & ~rd_n;
    assign cpu_dout = cpu_doe ? r_q.hold : '0;

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int DATA_W   = 8,
    parameter int TICK_DIV = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              write_evt,
    input logic              adc_wr_n,
    input logic              adc_rd_n,
    input logic [DATA_W-1:0] adc_data,
    input logic [DATA_W-1:0] hold,
    input logic              busy
);
    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        write_evt |=> !adc_wr_n);

    assert_start_still_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !write_evt) |=> $stable(adc_wr_n));

    assert_read_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(adc_rd_n));

    assert_capture_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_rd_n) |-> (hold == $past(adc_data)));

    assert_busy_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        write_evt |=> busy);

    assert_busy_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_rd_n) && !$past(write_evt)) |-> !busy);

    generate
        if (TICK_DIV > 1) begin : g_tick
            assert_tick_spaced_R5: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

bind adc_slow_seq adc_seq_chk #(.DATA_W(DATA_W), .TICK_DIV(TICK_DIV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .write_evt (write_evt),
    .adc_wr_n  (adc_wr_n),
    .adc_rd_n  (adc_rd_n),
    .adc_data  (adc_data),
    .hold      (hold_q),
    .busy      (busy)
);

// File: tb/tb_adc_slow_seq.sv
module tb_adc_slow_seq;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int N    = 4;
    localparam int DIV  = 2;
    localparam int CONV = 20;
    localparam int WATCHDOG = 20000;

    logic clk = 0, rst_n = 0;
    logic cs = 0, wr_n = 1, rd_n = 1;
    logic [DW-1:0] cpu_dout;
    logic cpu_doe, busy, adc_wr_n, adc_rd_n;
    logic adc_intr_n = 1;
    logic [DW-1:0] adc_data = '0;

    adc_slow_seq #(.DATA_W(DW), .STAGES(N), .TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr_n(wr_n), .rd_n(rd_n),
        .cpu_dout(cpu_dout), .cpu_doe(cpu_doe), .busy(busy),
        .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n),
        .adc_intr_n(adc_intr_n), .adc_data(adc_data));

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0, cmp_en = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- converter model ----------------
    bit adc_auto = 1, man_intr_n = 1, auto_intr = 1, prev_wr = 1;
    int conv_cnt = 0;
    always @(negedge clk) begin
        if (!prev_wr && adc_wr_n) conv_cnt = CONV;
        else if (conv_cnt > 0) begin
            conv_cnt--;
            if (conv_cnt == 0) auto_intr = 0;
        end
        if (!adc_rd_n) auto_intr = 1;
        prev_wr = adc_wr_n;
        adc_intr_n = adc_auto ? auto_intr : man_intr_n;
    end

    // ---------------- reference model ----------------
    int m_tcnt, m_ones;
    bit rq[$];
    bit m_tick, m_wr, m_cap, m_old, m_busy;
    logic [DW-1:0] m_hold;
    int wr_low = 0, rd_low = 0, last_wr_w = 0, last_rd_w = 0;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_tcnt = 0; m_ones = N; m_hold = '0; m_busy = 0;
            rq.delete();
            for (int i = 0; i < N; i++) rq.push_back(1'b1);
        end else begin
            m_tick = (m_tcnt == DIV-1);
            m_tcnt = m_tick ? 0 : m_tcnt + 1;
            m_wr  = cs && !wr_n;
            m_cap = 0;
            if (m_tick) begin
                m_old = rq[0];
                rq.push_back(adc_intr_n);
                void'(rq.pop_front());
                if (!m_old && rq[0]) m_cap = 1;
            end
            if (m_wr) m_ones = 0;
            else if (m_tick && m_ones < N) m_ones++;
            if (m_cap) m_hold = adc_data;
            if (m_wr) m_busy = 1;
            else if (m_cap) m_busy = 0;
        end
        #1;
        if (rst_n && cmp_en) begin
            check("R2/R3 adc_wr_n", adc_wr_n, (m_ones >= N) ? 1 : 0);
            check("R4/R5 adc_rd_n", adc_rd_n, rq[0]);
            check("R8 busy", busy, m_busy);
            check("R7 cpu_doe", cpu_doe, (cs && !rd_n) ? 1 : 0);
            check("R6/R7 cpu_dout", cpu_dout, (cs && !rd_n) ? m_hold : 0);
        end
        if (!adc_wr_n) wr_low++; else begin if (wr_low > 0) last_wr_w = wr_low; wr_low = 0; end
        if (!adc_rd_n) rd_low++; else begin if (rd_low > 0) last_rd_w = rd_low; rd_low = 0; end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cpu_write(int len, bit sel);
        @(negedge clk); cs = sel; wr_n = 0;
        repeat (len) @(negedge clk);
        cs = 0; wr_n = 1;
    endtask

    task automatic cpu_read(logic [DW-1:0] exp, string req);
        @(negedge clk); cs = 1; rd_n = 0;
        #1;
        check({req, " read enable"}, cpu_doe, 1);
        check({req, " read data"}, cpu_dout, exp);
        @(negedge clk); cs = 0; rd_n = 1;
        #1;
        check("R7 released enable", cpu_doe, 0);
        check("R7 released data", cpu_dout, 0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1
        check("R1 adc_wr_n", adc_wr_n, 1);
        check("R1 adc_rd_n", adc_rd_n, 1);
        check("R1 busy", busy, 0);
        check("R1 cpu_doe", cpu_doe, 0);
        cmp_en = 1;
        cpu_read('0, "R1");

        // R9: unselected write is ignored
        cpu_write(1, 0);
        repeat (N*DIV + 2) @(negedge clk);
        check("R9 busy", busy, 0);
        check("R9 adc_wr_n", adc_wr_n, 1);

        // Conversion 1, single-cycle write
        adc_data = 8'hA5;
        cpu_write(1, 1);
        check("R8 busy after write", busy, 1);
        wait_idle();
        check("R3 start width low", (last_wr_w >= (N-1)*DIV+1) ? 1 : 0, 1);
        check("R3 start width high", (last_wr_w <= N*DIV) ? 1 : 0, 1);
        check("R4 read width", last_rd_w, N*DIV);
        check("R8 idle after capture", busy, 0);
        adc_data = 8'h00;
        cpu_read(8'hA5, "R6");

        // Conversion 2, write held and phase shifted by one cycle
        @(negedge clk);
        adc_data = 8'h3C;
        cpu_write(3, 1);
        wait_idle();
        check("R3 held write extends", (last_wr_w >= (N-1)*DIV+3) ? 1 : 0, 1);
        cpu_read(8'h3C, "R6");

        // Conversion 3, data changes during read strobe
        adc_data = 8'h5A;
        cpu_write(1, 1);
        for (int i = 0; i < 500 && adc_rd_n; i++) @(negedge clk);
        adc_data = 8'hC3;
        wait_idle();
        cpu_read(8'hC3, "R6");

        // Manual done patterns through the delay line
        adc_auto = 0;
        man_intr_n = 0; repeat (3)  @(negedge clk);
        man_intr_n = 1; repeat (5)  @(negedge clk);
        man_intr_n = 0; adc_data = 8'h81; repeat (12) @(negedge clk);
        man_intr_n = 1; repeat (N*DIV + 4) @(negedge clk);
        check("R4 rd back high", adc_rd_n, 1);
        cpu_read(8'h81, "R6");
        man_intr_n = 0; repeat (1) @(negedge clk);
        man_intr_n = 1; adc_data = 8'h7E; repeat (N*DIV + 4) @(negedge clk);
        adc_auto = 1;
        repeat (4) @(negedge clk);

        done = 1;
        finish_run();
    end
endmodule